// File: doc/BRIEF.md
# LED Grayscale Clock Sequencer

This block drives the grayscale clock and the row-select code for a multiplexed LED driver that keeps its frame in its own memory. The block runs from one system clock at eight times the grayscale pulse rate. With the defaults, that is 16 MHz for a 2 MHz pulse train. While enabled, it sends bursts of exactly 257 grayscale pulses. Each pulse is high for four system cycles and low for four.

After each burst the grayscale clock stays low for a blanking gap whose length is programmable. The row address advances inside that gap. The row address is a 5-bit binary code that an external decoder expands into 32 row lines. When row 31 has been served, the address wraps to 0 and a one-cycle end-of-frame pulse is raised.

After the frame data has been loaded into the driver, the block cycles through the rows with no further host action.

The controller has three states:

- `ST_IDLE` (after reset): the clock is parked low.
- `ST_BURST`: pulses are emitted.
- `ST_GAP`: blanking.

The transitions are:

- **start**: `ST_IDLE` to `ST_BURST` when enable is sampled high.
- **burst_done**: `ST_BURST` to `ST_GAP` on the falling half of pulse 257.
- **resume**: `ST_GAP` to `ST_BURST` when the gap count expires and enable is high.
- **park**: `ST_GAP` to `ST_IDLE` when the gap count expires and enable is low.

Top module: `gs_row_sequencer`

## Requirements
- R1: Every burst holds exactly 257 rising edges of `gsclk`, counted between consecutive `row_step` pulses (the first count runs from reset).
- R2: Within a burst, `gsclk` is high for 4 system cycles and low for 4 system cycles for each pulse. The pulse period is 8 system cycles with a 50 % duty cycle.
- R3: Between the last falling edge of one burst and the first rising edge of the next, `gsclk` is low for exactly G system cycles. G is derived from `gap_cycles` as follows: a value of 0 selects 32; values below 24 give 24; values above 40 give 40; any other value is used as given.
- R4: `row_addr` changes only while `gsclk` is low, and only in the cycle where `row_step` is high. That cycle is the second low cycle after the final falling edge of the burst.
- R5: `row_addr` is 0 after reset. It increases by exactly 1 (modulo 32) at each `row_step`.
- R6: `frame_end` is a single-cycle pulse. It is high together with `row_step` exactly when `row_addr` wraps from 31 to 0, and never at any other time.
- R7: From `ST_IDLE`, a high `enable` sampled at a clock edge makes `gsclk` rise at that same edge. A low `enable` does not cut a burst short: the burst and its row step complete, and no further pulse follows while `enable` stays low.
- R8: `gap_cycles` is sampled at the edge where the final pulse of a burst falls. Changing it during the gap has no effect on that gap.
- R9: While reset is asserted and until `enable` is raised, `gsclk`, `row_step` and `frame_end` are 0 and `row_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 8x the grayscale pulse rate |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; sampled at idle and at the end of each gap |
| gap_cycles | input | 8 | Requested blanking length in system cycles (0 = default) |
| gsclk | output | 1 | Gated grayscale clock to the LED driver |
| row_addr | output | 5 | Binary row-select code |
| row_step | output | 1 | One-cycle strobe marking a new row address |
| frame_end | output | 1 | One-cycle strobe when the address wraps after row 31 |

## Verification
The embedded assertions are evaluated on every cycle. They check four things:

- exactly 257 rising edges fall between row strobes;
- a pulse never lasts only one cycle high;
- the row address never moves while `gsclk` is high or has just fallen;
- `frame_end` is single-cycle and coincides with a wrap to row 0.

Only the bench scenarios can show the exact 4/4 pulse shape and the exact blanking length after clamping, including lengths changed in mid-gap. The same holds for the full 32-row walk with its wrap, and for the way enable starts and parks the sequencer at burst boundaries.

// File: rtl/gs_seq_pkg.sv
package gs_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/gs_gap_clamp.sv
module gs_gap_clamp #(
    parameter int GAP_W       = 8,
    parameter int GAP_MIN     = 24,
    parameter int GAP_MAX     = 40,
    parameter int GAP_DEFAULT = 32
) (
    input  logic [GAP_W-1:0] raw_len,
    output logic [GAP_W-1:0] eff_len
);

    localparam logic [GAP_W-1:0] LO  = GAP_W'(GAP_MIN);
    localparam logic [GAP_W-1:0] HI  = GAP_W'(GAP_MAX);
    localparam logic [GAP_W-1:0] DEF = GAP_W'(GAP_DEFAULT);

    always_comb begin
        if (raw_len == '0) begin
            eff_len = DEF;
        end else if (raw_len < LO) begin
            eff_len = LO;
        end else if (raw_len > HI) begin
            eff_len = HI;
        end else begin
            eff_len = raw_len;
        end
    end

    // Clamped length stays inside the legal window (R3)
    always_comb begin
        assert_clamp_window_R3: assert (eff_len >= LO && eff_len <= HI);
    end

endmodule

// File: rtl/gs_burst_fsm.sv
module gs_burst_fsm
    import gs_seq_pkg::*;
#(
    parameter int PULSES = 257,
    parameter int DIV    = 8,
    parameter int GAP_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [GAP_W-1:0] gap_len,
    output logic             gsclk,
    output logic             gap_first
);

    localparam int PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int CNT_W = $clog2(PULSES + 1);
    localparam int HALF  = DIV / 2;

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSES);

    seq_state_t         state_q, state_d;
    logic [PH_W-1:0]    ph_q, ph_nx;
    logic [CNT_W-1:0]   pcnt_q;
    logic [GAP_W-1:0]   gcnt_q;
    logic [GAP_W-1:0]   gap_q;
    logic               gsclk_q;
    logic               burst_done;
    logic               gap_expired;

    assign ph_nx       = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    assign burst_done  = (pcnt_q == CNT_LAST) && (ph_q == PH_FALL);
    assign gap_expired = (gcnt_q == gap_q - 1'b1);

    // Next-state decode: start, burst_done, resume, park
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_BURST;          // start
            end
            ST_BURST: begin
                if (burst_done) state_d = ST_GAP;        // burst_done
            end
            ST_GAP: begin
                if (gap_expired) begin
                    state_d = enable ? ST_BURST          // resume
                                     : ST_IDLE;          // park
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= '0;
            pcnt_q  <= '0;
            gcnt_q  <= '0;
            gap_q   <= '0;
            gsclk_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    gsclk_q <= 1'b0;
                    if (state_d == ST_BURST) begin
                        ph_q    <= '0;
                        pcnt_q  <= CNT_W'(1);
                        gsclk_q <= 1'b1;
                    end
                end
                ST_BURST: begin
                    if (state_d == ST_GAP) begin
                        ph_q    <= '0;
                        pcnt_q  <= '0;
                        gcnt_q  <= '0;
                        gap_q   <= gap_len;
                        gsclk_q <= 1'b0;
                    end else begin
                        ph_q    <= ph_nx;
                        gsclk_q <= (ph_nx < PH_HALF);
                        if (ph_nx == '0) pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    gcnt_q  <= gcnt_q + 1'b1;
                    gsclk_q <= 1'b0;
                    if (state_d == ST_BURST) begin
                        ph_q    <= '0;
                        pcnt_q  <= CNT_W'(1);
                        gcnt_q  <= '0;
                        gsclk_q <= 1'b1;
                    end
                end
                default: begin
                    gsclk_q <= 1'b0;
                end
            endcase
        end
    end

    assign gsclk     = gsclk_q;
    assign gap_first = (state_q == ST_GAP) && (gcnt_q == '0);

    // Outside a burst the grayscale clock is parked low (R3)
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BURST) |-> !gsclk_q);

    // Gap length held for the whole gap once latched (R8)
    assert_gap_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && $past(state_q) == ST_GAP) |-> $stable(gap_q));

    // A burst never ends before its pulse count is complete (R1)
    assert_no_early_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && state_d == ST_GAP) |-> (pcnt_q == CNT_LAST));

endmodule

// File: rtl/gs_row_counter.sv
module gs_row_counter #(
    parameter int ROWS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance,
    output logic [$clog2(ROWS)-1:0]  addr,
    output logic                     step,
    output logic                     eof
);

    localparam int AW = $clog2(ROWS);
    localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

    logic [AW-1:0] addr_q;
    logic          step_q;
    logic          eof_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            step_q <= 1'b0;
            eof_q  <= 1'b0;
        end else if (advance) begin
            addr_q <= (addr_q == LAST_ROW) ? '0 : addr_q + 1'b1;
            step_q <= 1'b1;
            eof_q  <= (addr_q == LAST_ROW);
        end else begin
            step_q <= 1'b0;
            eof_q  <= 1'b0;
        end
    end

    assign addr = addr_q;
    assign step = step_q;
    assign eof  = eof_q;

    // End of frame comes only with a step onto row 0 (R6)
    assert_eof_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |-> (step_q && addr_q == '0));

    // End of frame lasts one cycle (R6)
    assert_eof_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |=> !eof_q);

endmodule

// File: rtl/gs_row_sequencer.sv
module gs_row_sequencer #(
    parameter int PULSES      = 257,
    parameter int ROWS        = 32,
    parameter int DIV         = 8,
    parameter int GAP_W       = 8,
    parameter int GAP_MIN     = 24,
    parameter int GAP_MAX     = 40,
    parameter int GAP_DEFAULT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [GAP_W-1:0]         gap_cycles,
    output logic                     gsclk,
    output logic [$clog2(ROWS)-1:0]  row_addr,
    output logic                     row_step,
    output logic                     frame_end
);

    localparam int RC_W = $clog2(PULSES + 2);

    logic [GAP_W-1:0] gap_eff;
    logic             gap_first;

    gs_gap_clamp #(
        .GAP_W       (GAP_W),
        .GAP_MIN     (GAP_MIN),
        .GAP_MAX     (GAP_MAX),
        .GAP_DEFAULT (GAP_DEFAULT)
    ) u_clamp (
        .raw_len (gap_cycles),
        .eff_len (gap_eff)
    );

    gs_burst_fsm #(
        .PULSES (PULSES),
        .DIV    (DIV),
        .GAP_W  (GAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .gap_len   (gap_eff),
        .gsclk     (gsclk),
        .gap_first (gap_first)
    );

    gs_row_counter #(
        .ROWS (ROWS)
    ) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (gap_first),
        .addr    (row_addr),
        .step    (row_step),
        .eof     (frame_end)
    );

    // Observation counter for the pulse-count check
    logic            gsclk_d;
    logic [RC_W-1:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gsclk_d  <= 1'b0;
            rise_cnt <= '0;
        end else begin
            gsclk_d <= gsclk;
            if (row_step) begin
                rise_cnt <= (gsclk && !gsclk_d) ? RC_W'(1) : '0;
            end else if (gsclk && !gsclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // Exactly PULSES rising edges between row steps (R1)
    assert_burst_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        row_step |-> (rise_cnt == RC_W'(PULSES)));

    // A pulse is never a single-cycle high (R2)
    assert_gsclk_min_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gsclk) |=> gsclk);

    // Address moves only with gsclk low now and in the previous cycle (R4)
    assert_addr_in_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr != $past(row_addr)) |-> (!gsclk && !$past(gsclk) && row_step));

endmodule

// File: tb/gs_row_sequencer_tb.sv
module gs_row_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] gap_cycles = 8'd0;
    logic       gsclk;
    logic [4:0] row_addr;
    logic       row_step;
    logic       frame_end;

    gs_row_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .gap_cycles (gap_cycles),
        .gsclk      (gsclk),
        .row_addr   (row_addr),
        .row_step   (row_step),
        .frame_end  (frame_end)
    );

    always #10 clk = ~clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    function automatic void chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic int exp_gap_of(int g);
        if (g == 0)  return 32;
        if (g < 24)  return 24;
        if (g > 40)  return 40;
        return g;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Monitor state
    bit   mon_on = 0;
    logic prev_g = 1'b0;
    int   high_run = 0, low_run = 0, pulses = 0, since_fall = 0;
    int   exp_addr = 0, exp_gap = 0, total_rises = 0, steps = 0;
    bit   gap_pending = 0;
    event ev_last_fall;

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (gsclk && !prev_g) begin
                total_rises++;
                if (pulses == 0) begin
                    if (gap_pending) chk(low_run == exp_gap, "R3 gap length", low_run, exp_gap);
                    gap_pending = 0;
                end else begin
                    chk(low_run == 4, "R2 low half", low_run, 4);
                end
                pulses++;
                if (pulses > 257) chk(0, "R1 too many pulses", pulses, 257);
                high_run = 1;
            end else if (gsclk) begin
                high_run++;
            end
            if (!gsclk && prev_g) begin
                chk(high_run == 4, "R2 high half", high_run, 4);
                low_run = 1;
                since_fall = 0;
                if (pulses == 257) begin
                    exp_gap = exp_gap_of(int'(gap_cycles));
                    gap_pending = 1;
                    -> ev_last_fall;
                end
            end else if (!gsclk) begin
                low_run++;
                since_fall++;
            end
            if (row_step) begin
                chk(pulses == 257, "R1 pulses per burst", pulses, 257);
                chk(since_fall == 1 && !gsclk, "R4 step timing", since_fall, 1);
                chk(int'(row_addr) == (exp_addr + 1) % 32, "R5 address step",
                    int'(row_addr), (exp_addr + 1) % 32);
                chk(frame_end == (exp_addr == 31), "R6 frame end",
                    int'(frame_end), int'(exp_addr == 31));
                exp_addr = (exp_addr + 1) % 32;
                pulses = 0;
                steps++;
            end else begin
                if (int'(row_addr) != exp_addr)
                    chk(0, "R4 address moved without step", int'(row_addr), exp_addr);
                if (frame_end)
                    chk(0, "R6 frame end without step", 1, 0);
            end
            prev_g = gsclk;
        end
    end

    // Gap setting changes right after the final fall (R8 and R3 clamping)
    int pick_idx = 0;
    function automatic logic [7:0] pick_gap(int idx);
        case (idx)
            0: return 8'd5;
            1: return 8'd255;
            2: return 8'd24;
            3: return 8'd40;
            4: return 8'd23;
            5: return 8'd41;
            6: return 8'd0;
            default: return 8'($urandom_range(0, 70));
        endcase
    endfunction

    initial begin
        forever begin
            @(ev_last_fall);
            #3;
            gap_cycles = pick_gap(pick_idx);
            pick_idx++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R1 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int r0;
        int s0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(gsclk == 0 && row_step == 0 && frame_end == 0, "R9 reset outputs",
            int'(gsclk) + int'(row_step) + int'(frame_end), 0);
        chk(row_addr == 0, "R9 reset address", int'(row_addr), 0);
        #1 rst_n = 1'b1;
        mon_on = 1;
        repeat (5) @(negedge clk);
        chk(gsclk == 0 && row_addr == 0, "R9 idle before enable",
            int'(gsclk) + int'(row_addr), 0);

        // start from idle: rising edge at the same clock edge that samples enable
        #1 enable = 1'b1;
        @(negedge clk);
        chk(gsclk == 1, "R7 start from idle", int'(gsclk), 1);

        // full frame plus the wrap and one more row
        while (steps < 34) @(negedge clk);
        chk(exp_addr == 2, "R5 address after frame walk", int'(row_addr), 2);

        // drop enable mid-burst: burst and its step finish, then park
        while (!gsclk) @(negedge clk);
        s0 = steps;
        #1 enable = 1'b0;
        while (steps == s0) @(negedge clk);
        r0 = total_rises;
        repeat (3000) @(negedge clk);
        chk(total_rises == r0, "R7 no pulses while disabled", total_rises, r0);
        chk(gsclk == 0, "R7 parked low", int'(gsclk), 0);
        chk(steps == s0 + 1, "R7 burst completed before park", steps, s0 + 1);

        // restart
        gap_pending = 0;
        @(negedge clk);
        #1 enable = 1'b1;
        @(negedge clk);
        chk(gsclk == 1, "R7 restart from idle", int'(gsclk), 1);
        s0 = steps;
        while (steps < s0 + 2) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule